// File: doc/BRIEF.md
# Edge-Triggered Boolean Latch Bank

A bank of boolean storage channels, sixteen by default, that all share one set of controls. In delay mode each output follows its input one enabled cycle later. In latch mode the whole input vector is captured at once on a qualifying edge, and the outputs hold between captures. Two control lines give a qualifying edge: a rising transition on one, or a falling transition on the other.

Both edges are found inside the block. Each control line is compared with its own copy registered on the previous enabled cycle. A low-active initialise input overrides both modes and drives every channel to a selectable constant. All updates happen only when the cycle-enable strobe is high, so the block can run at a slower program-cycle rate than its clock.

Top module: `bool_latch_bank`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` becomes all zeros and both registered control copies become 0.
- R2: With `init_n` high and `bypass` high on an enabled cycle, `dout` takes the value of `din` at that edge. The control lines then have no effect on `dout`.
- R3: With `init_n` high and `bypass` low, an enabled cycle where `cap_rise` is 1 and its registered copy is 0 loads `din` into `dout`.
- R4: With `init_n` high and `bypass` low, an enabled cycle where `cap_fall` is 0 and its registered copy is 1 loads `din` into `dout`.
- R5: In latch mode on an enabled cycle with no qualifying edge, `dout` keeps its previous value.
- R6: On an enabled cycle with `init_n` low, every bit of `dout` becomes `init_val`. This overrides both delay mode and edge capture.
- R7: On a cycle with `cyc_en` low, `dout` and the registered control copies do not change. A control level that changes while `cyc_en` is low is judged against the copy from the last enabled cycle.
- R8: When both qualifying edges occur on the same enabled cycle, `dout` loads `din` once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Cycle-enable strobe |
| bypass | input | 1 | 1 selects delay mode, 0 selects latch mode |
| cap_rise | input | 1 | Capture control, acts on its rising edge |
| cap_fall | input | 1 | Capture control, acts on its falling edge |
| init_n | input | 1 | Initialise, active low |
| init_val | input | 1 | Constant loaded into all channels during initialise |
| din | input | WIDTH | Channel inputs |
| dout | output | WIDTH | Channel outputs |

## Verification
The bench builds the block with the default WIDTH of 16. Each capture uses a different 16-bit pattern, so a missed or extra load shows up as a wrong word at the outputs. Stepping the control lines one level per cycle produces rising, falling, simultaneous and absent edges in turn. Holding the strobe low while a control line moves shows whether the registered copies freeze.

// File: rtl/bool_latch_bank.sv
module bool_latch_bank #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             bypass,
  input  logic             cap_rise,
  input  logic             cap_fall,
  input  logic             init_n,
  input  logic             init_val,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic rise_q, fall_q;
  logic hit;

  assign hit = (cap_rise & ~rise_q) | (~cap_fall & fall_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      dout   <= '0;
    end else if (cyc_en) begin
      rise_q <= cap_rise;
      fall_q <= cap_fall;
      if (!init_n)
        dout <= {WIDTH{init_val}};
      else if (bypass || hit)
        dout <= din;
    end
  end

endmodule

module bool_latch_bank_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_en,
  input logic             bypass,
  input logic             cap_rise,
  input logic             cap_fall,
  input logic             init_n,
  input logic             init_val,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout
);

  logic seen_r, seen_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_r <= 1'b0;
      seen_f <= 1'b0;
    end else if (cyc_en) begin
      seen_r <= cap_rise;
      seen_f <= cap_fall;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> dout == '0);

  // R6
  init_force_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && !init_n) |=> dout == {WIDTH{$past(init_val)}});

  // R2
  delay_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && init_n && bypass) |=> dout == $past(din));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> $stable(dout));

  // R5
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && init_n && !bypass && !(cap_rise && !seen_r) && !(!cap_fall && seen_f))
    |=> $stable(dout));

  // R3
  rise_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && init_n && !bypass && cap_rise && !seen_r) |=> dout == $past(din));

  // R4
  fall_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && init_n && !bypass && !cap_fall && seen_f) |=> dout == $past(din));

endmodule

bind bool_latch_bank bool_latch_bank_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/bool_latch_bank_tb_top.sv
module bool_latch_bank_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, cyc_en, bypass, cap_rise, cap_fall, init_n, init_val;
  logic [W-1:0] din, dout;

  always #2 clk = ~clk;

  bool_latch_bank #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .bypass(bypass),
    .cap_rise(cap_rise), .cap_fall(cap_fall), .init_n(init_n),
    .init_val(init_val), .din(din), .dout(dout)
  );

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_out = '0;
  logic m_r = 1'b0, m_f = 1'b0;

  task automatic step(input logic r, input logic en, input logic byp,
                      input logic cr, input logic cf, input logic inn,
                      input logic iv, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    rst = r; cyc_en = en; bypass = byp; cap_rise = cr; cap_fall = cf;
    init_n = inn; init_val = iv; din = d;
    if (r) begin
      m_out = '0; m_r = 1'b0; m_f = 1'b0;
    end else if (en) begin
      if (!inn) m_out = {W{iv}};
      else if (byp || (cr && !m_r) || (!cf && m_f)) m_out = d;
      m_r = cr; m_f = cf;
    end
    exp_q.push_back(m_out);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dout !== e) begin
        fails++;
        $display("FAIL %s: dout=%h expected=%h", t, dout, e);
      end
    end
  end

  initial begin
    #(4 * 2000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1,1,0,0,0,1,0,16'hFFFF,"R1 reset");
    step(1,1,0,0,0,1,0,16'hFFFF,"R1 reset");
    step(0,1,0,0,0,1,0,16'h1234,"R5 no edge hold");
    step(0,1,0,1,0,1,0,16'hA5A5,"R3 rising capture");
    step(0,1,0,1,0,1,0,16'h5A5A,"R5 rise held high");
    step(0,1,0,0,0,1,0,16'h0F0F,"R5 rise falling ignored");
    step(0,1,0,0,1,1,0,16'hC3C3,"R5 fall line rising ignored");
    step(0,1,0,0,0,1,0,16'h9669,"R4 falling capture");
    step(0,1,0,0,1,1,0,16'h1111,"R5 fall high again");
    step(0,1,0,1,0,1,0,16'h7E81,"R8 both edges");
    step(0,1,0,1,0,1,0,16'h2222,"R5 after both");
    step(0,1,1,0,1,1,0,16'hBEEF,"R2 delay ignores controls");
    step(0,1,1,1,0,1,0,16'h0001,"R2 delay next word");
    step(0,1,1,1,0,1,0,16'h8000,"R2 delay no edge");
    step(0,1,1,0,0,0,1,16'h3333,"R6 init over delay");
    step(0,1,0,1,0,0,0,16'h4444,"R6 init over rising capture");
    step(0,1,0,0,0,1,0,16'h5555,"R5 after init");
    step(0,0,0,1,0,1,0,16'hDEAD,"R7 disabled edge ignored");
    step(0,0,0,1,0,0,1,16'hCAFE,"R7 disabled init ignored");
    step(0,1,0,1,0,1,0,16'h6789,"R7 edge judged against frozen copy");
    step(1,1,0,0,0,1,0,16'hFFFF,"R1 mid-run reset");
    step(0,1,0,0,0,1,0,16'hFFFF,"R1 no false edge after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule